// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines and turns them into two requests for a processor core. One is a fast request and the other is a normal request. Software classes each line as fast or normal and enables it through a small register bus. Sixteen vector slots each name one source line and hold the entry address of the handler for that line.

When the core takes a normal request, it reads the handler address. The address comes from the lowest-numbered enabled slot whose bound line is currently requesting. If no such slot exists, a default address is returned instead.

Fast-class lines never take part in vectoring. They only drive the fast request output, and the core enters its fast handler on its own. Source lines are expected to be already conditioned (level, synchronous to the clock). The request outputs and the handler address are combinational functions of the source lines and the register contents.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every register reads zero. Every source is disabled and classed normal, every slot is disabled, the default address is 0, and both request outputs are low.
- R2: A source whose class bit (register 0x02, bit n for source n) is 1 can only raise `fiq_o`. A source whose class bit is 0 can only raise `irq_o`.
- R3: A source whose enable bit (register 0x03) is 0 raises neither output and has no effect on the handler address.
- R4: An enabled, active fast-class source never changes the handler address, even when an enabled slot is bound to it.
- R5: Slot k is bound as follows. Its handler address goes to 0x40+k. Its control register goes to 0x80+k, with the source number in bits [4:0] and the slot enable in bit 5. Once bound and enabled, slot k's address is reported while its source is an enabled, active normal-class line (for example slot 10 bound to source 15).
- R6: When several enabled slots match active lines, the lowest-numbered slot's address is reported.
- R7: When no enabled slot matches an active normal line, the handler address equals the default register (0x06). This includes slots that are bound but disabled, and the case where no line is active at all.
- R8: `irq_o` is high exactly when some enabled, active normal-class source exists. `fiq_o` is high exactly when some enabled, active fast-class source exists.
- R9: Writing to 0x04 sets the enable bits that are 1 in the data. Writing to 0x05 clears them. Bits written as 0 keep their value in both cases.
- R10: Registers 0x02, 0x03, 0x06 and the slot registers read back what was written. Slot control registers keep only bits [5:0] and read zero above them.
- R11: Register 0x00 reads the raw source lines, and register 0x01 reads the source lines ANDed with the enable register. Register 0x07 reads the same value as `vec_addr_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Conditioned interrupt source lines |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with `bus_sel`) |
| bus_addr | input | 8 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not selected |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| vec_addr_o | output | 32 | Current handler address |

## Verification
The assertions take for granted three things about the inputs. Source lines and bus signals are free of unknown values from reset onward. A write lasts a single clock with the address and data stable around the edge. Source numbers written into slot control fields lie below the source count.

The bench drives every input at the falling edge and writes only mapped addresses. It fills slot fields with values in range, so these conditions always hold. Random class, enable and slot bindings are mixed with directed cases: the slot 10 binding of source 15, overlapping slots, a fast-class line bound to a slot, and disabled bound slots.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   localparam int unsigned BUS_DW = 32;
   localparam int unsigned BUS_AW = 8;

   localparam logic [BUS_AW-1:0] RA_RAW      = 8'h00;
   localparam logic [BUS_AW-1:0] RA_MASKED   = 8'h01;
   localparam logic [BUS_AW-1:0] RA_CLASS    = 8'h02;
   localparam logic [BUS_AW-1:0] RA_ENABLE   = 8'h03;
   localparam logic [BUS_AW-1:0] RA_EN_SET   = 8'h04;
   localparam logic [BUS_AW-1:0] RA_EN_CLR   = 8'h05;
   localparam logic [BUS_AW-1:0] RA_DEFAULT  = 8'h06;
   localparam logic [BUS_AW-1:0] RA_HANDLER  = 8'h07;
   localparam logic [BUS_AW-1:0] RA_SLOT_ADR = 8'h40;
   localparam logic [BUS_AW-1:0] RA_SLOT_CTL = 8'h80;

   localparam int unsigned CTL_EN_BIT   = 5;
   localparam int unsigned MAX_SLOTS    = 64;
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
   import ivc_pkg::*;
#(
   parameter int unsigned NSRC  = 32,
   parameter int unsigned NSLOT = 16,
   parameter int unsigned AW    = 32,
   localparam int unsigned SW   = $clog2(NSRC)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_sel,
   input  logic                       bus_wr,
   input  logic [BUS_AW-1:0]          bus_addr,
   input  logic [BUS_DW-1:0]          bus_wdata,
   output logic [BUS_DW-1:0]          bus_rdata,
   input  logic [NSRC-1:0]            src_i,
   input  logic [AW-1:0]              cur_addr,
   output logic [NSRC-1:0]            class_q,
   output logic [NSRC-1:0]            en_q,
   output logic [AW-1:0]              def_q,
   output logic [NSLOT-1:0][AW-1:0]   slot_addr_q,
   output logic [NSLOT-1:0][SW-1:0]   slot_src_q,
   output logic [NSLOT-1:0]           slot_en_q
);
   logic wr_en;
   assign wr_en = bus_sel & bus_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         class_q <= '0;
         en_q    <= '0;
         def_q   <= '0;
      end else if (wr_en) begin
         case (bus_addr)
            RA_CLASS:   class_q <= bus_wdata[NSRC-1:0];
            RA_ENABLE:  en_q    <= bus_wdata[NSRC-1:0];
            RA_EN_SET:  en_q    <= en_q | bus_wdata[NSRC-1:0];
            RA_EN_CLR:  en_q    <= en_q & ~bus_wdata[NSRC-1:0];
            RA_DEFAULT: def_q   <= bus_wdata[AW-1:0];
            default: ;
         endcase
      end
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam logic [BUS_AW-1:0] A_ADR = RA_SLOT_ADR + BUS_AW'(s);
      localparam logic [BUS_AW-1:0] A_CTL = RA_SLOT_CTL + BUS_AW'(s);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_addr_q[s] <= '0;
            slot_src_q[s]  <= '0;
            slot_en_q[s]   <= 1'b0;
         end else if (wr_en && bus_addr == A_ADR) begin
            slot_addr_q[s] <= bus_wdata[AW-1:0];
         end else if (wr_en && bus_addr == A_CTL) begin
            slot_src_q[s]  <= bus_wdata[SW-1:0];
            slot_en_q[s]   <= bus_wdata[CTL_EN_BIT];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         case (bus_addr)
            RA_RAW:     bus_rdata = BUS_DW'(src_i);
            RA_MASKED:  bus_rdata = BUS_DW'(src_i & en_q);
            RA_CLASS:   bus_rdata = BUS_DW'(class_q);
            RA_ENABLE:  bus_rdata = BUS_DW'(en_q);
            RA_DEFAULT: bus_rdata = BUS_DW'(def_q);
            RA_HANDLER: bus_rdata = BUS_DW'(cur_addr);
            default: ;
         endcase
         for (int s = 0; s < NSLOT; s++) begin
            if (bus_addr == RA_SLOT_ADR + BUS_AW'(s))
               bus_rdata = BUS_DW'(slot_addr_q[s]);
            if (bus_addr == RA_SLOT_CTL + BUS_AW'(s)) begin
               bus_rdata = BUS_DW'(slot_src_q[s]);
               bus_rdata[CTL_EN_BIT] = slot_en_q[s];
            end
         end
      end
   end

   assert_enable_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == RA_EN_SET) |=>
      ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
   assert_enable_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == RA_EN_CLR) |=>
      ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));
   assert_default_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == RA_DEFAULT) |=> (def_q == $past(bus_wdata[AW-1:0])));
   assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> ($stable(class_q) && $stable(en_q) && $stable(def_q)));
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
   parameter int unsigned NSRC  = 32,
   parameter int unsigned NSLOT = 16,
   parameter int unsigned AW    = 32,
   localparam int unsigned SW   = $clog2(NSRC)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NSRC-1:0]           irq_act,
   input  logic [NSLOT-1:0][SW-1:0]  slot_src,
   input  logic [NSLOT-1:0]          slot_en,
   input  logic [NSLOT-1:0][AW-1:0]  slot_addr,
   input  logic [AW-1:0]             def_addr,
   output logic [AW-1:0]             vec_addr,
   output logic                      vec_hit
);
   logic [NSLOT-1:0] slot_hit;

   for (genvar s = 0; s < NSLOT; s++) begin : g_hit
      assign slot_hit[s] = slot_en[s] & irq_act[slot_src[s]];
   end

   always_comb begin
      vec_addr = def_addr;
      vec_hit  = 1'b0;
      for (int s = NSLOT - 1; s >= 0; s--) begin
         if (slot_hit[s]) begin
            vec_addr = slot_addr[s];
            vec_hit  = 1'b1;
         end
      end
   end

   assert_idle_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_act == '0) |-> (vec_addr == def_addr && !vec_hit));
   assert_slot0_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      slot_hit[0] |-> (vec_addr == slot_addr[0]));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import ivc_pkg::*;
#(
   parameter int unsigned NSRC  = 32,
   parameter int unsigned NSLOT = 16,
   parameter int unsigned AW    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_i,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   output logic              irq_o,
   output logic              fiq_o,
   output logic [AW-1:0]     vec_addr_o
);
   localparam int unsigned SW = $clog2(NSRC);

   if (NSRC < 2 || NSRC > BUS_DW) begin : g_bad_nsrc
      $error("NSRC must lie in 2..BUS_DW");
   end
   if (SW > CTL_EN_BIT) begin : g_bad_field
      $error("source field overlaps slot enable bit");
   end
   if (NSLOT < 1 || NSLOT > MAX_SLOTS) begin : g_bad_nslot
      $error("NSLOT must lie in 1..MAX_SLOTS");
   end
   if (AW > BUS_DW) begin : g_bad_aw
      $error("AW must not exceed the bus width");
   end

   logic [NSRC-1:0]          class_q, en_q, act, irq_act, fiq_act;
   logic [AW-1:0]            def_q;
   logic [NSLOT-1:0][AW-1:0] slot_addr_q;
   logic [NSLOT-1:0][SW-1:0] slot_src_q;
   logic [NSLOT-1:0]         slot_en_q;
   logic                     vec_hit;

   ivc_regs #(.NSRC(NSRC), .NSLOT(NSLOT), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_i(src_i), .cur_addr(vec_addr_o),
      .class_q(class_q), .en_q(en_q), .def_q(def_q),
      .slot_addr_q(slot_addr_q), .slot_src_q(slot_src_q), .slot_en_q(slot_en_q)
   );

   assign act     = src_i & en_q;
   assign irq_act = act & ~class_q;
   assign fiq_act = act & class_q;
   assign irq_o   = |irq_act;
   assign fiq_o   = |fiq_act;

   ivc_prio #(.NSRC(NSRC), .NSLOT(NSLOT), .AW(AW)) u_prio (
      .clk(clk), .rst_n(rst_n),
      .irq_act(irq_act), .slot_src(slot_src_q), .slot_en(slot_en_q),
      .slot_addr(slot_addr_q), .def_addr(def_q),
      .vec_addr(vec_addr_o), .vec_hit(vec_hit)
   );

   assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> (!irq_o && !fiq_o && vec_addr_o == def_q));
   assert_fiq_has_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> ((src_i & class_q) != '0));
   assert_irq_has_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((src_i & ~class_q) != '0));
   assert_hit_needs_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_hit |-> irq_o);
   assert_reset_clear_R1: assert property (@(posedge clk)
      $past(!rst_n) |-> (en_q == '0 && class_q == '0 && slot_en_q == '0));
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 32;
   localparam int NL = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, fiq_o;
   logic [31:0] vec_addr_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_class, m_en, m_def;
   logic [31:0] m_saddr [NL];
   logic [4:0]  m_ssrc  [NL];
   logic        m_sen   [NL];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vector_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src_i),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .fiq_o(fiq_o), .vec_addr_o(vec_addr_o)
   );

   function automatic logic exp_irq(input logic [31:0] s);
      return |(s & m_en & ~m_class);
   endfunction
   function automatic logic exp_fiq(input logic [31:0] s);
      return |(s & m_en & m_class);
   endfunction
   function automatic logic [31:0] exp_vec(input logic [31:0] s);
      logic [31:0] nrm;
      nrm = s & m_en & ~m_class;
      for (int k = 0; k < NL; k++)
         if (m_sen[k] && nrm[m_ssrc[k]]) return m_saddr[k];
      return m_def;
   endfunction
   function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [31:0] s);
      if (a == 8'h00) return s;
      if (a == 8'h01) return s & m_en;
      if (a == 8'h02) return m_class;
      if (a == 8'h03) return m_en;
      if (a == 8'h06) return m_def;
      if (a == 8'h07) return exp_vec(s);
      if (a >= 8'h40 && a < 8'h40 + NL) return m_saddr[a - 8'h40];
      if (a >= 8'h80 && a < 8'h80 + NL)
         return {26'b0, m_sen[a - 8'h80], m_ssrc[a - 8'h80]};
      return 32'h0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      if (a == 8'h02) m_class = d;
      else if (a == 8'h03) m_en = d;
      else if (a == 8'h04) m_en = m_en | d;
      else if (a == 8'h05) m_en = m_en & ~d;
      else if (a == 8'h06) m_def = d;
      else if (a >= 8'h40 && a < 8'h40 + NL) m_saddr[a - 8'h40] = d;
      else if (a >= 8'h80 && a < 8'h80 + NL) begin
         m_ssrc[a - 8'h80] = d[4:0];
         m_sen[a - 8'h80]  = d[5];
      end
   endtask

   task automatic reg_read(input string req, input logic [7:0] a);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      chk(req, bus_rdata, exp_read(a, src_i));
      bus_sel = 1'b0;
   endtask

   task automatic chk_out(input string tag);
      #1;
      chk({tag, " irq R8"}, {31'b0, irq_o}, {31'b0, exp_irq(src_i)});
      chk({tag, " fiq R8"}, {31'b0, fiq_o}, {31'b0, exp_fiq(src_i)});
      chk({tag, " vec R5"}, vec_addr_o, exp_vec(src_i));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      m_class = '0; m_en = '0; m_def = '0;
      for (int k = 0; k < NL; k++) begin m_saddr[k] = '0; m_ssrc[k] = '0; m_sen[k] = 1'b0; end
      r = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      src_i = 32'hFFFF_FFFF;
      #1;
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
      chk("R1 fiq", {31'b0, fiq_o}, 32'h0);
      chk("R1 vec", vec_addr_o, 32'h0);
      reg_read("R1 enable", 8'h03);
      reg_read("R1 class", 8'h02);
      reg_read("R1 slot ctl", 8'h8A);
      src_i = '0;

      // R7: bound but not yet enabled slot gives default
      reg_write(8'h06, 32'hDEAD_0000);
      reg_write(8'h4A, 32'h1234_5678);
      reg_write(8'h8A, 32'h0000_000F);
      reg_write(8'h04, 32'h0000_8000);
      src_i = 32'h0000_8000;
      #1; chk("R7 unbound", vec_addr_o, 32'hDEAD_0000);
      chk_out("R7");
      // R5: enable slot 10 for source 15
      reg_write(8'h8A, 32'h0000_002F);
      #1; chk("R5 slot10", vec_addr_o, 32'h1234_5678);
      chk("R8 irq high", {31'b0, irq_o}, 32'h1);
      reg_read("R11 handler", 8'h07);
      reg_read("R10 ctl read", 8'h8A);
      // R6: lower slot bound to same source wins
      reg_write(8'h43, 32'hAAAA_0003);
      reg_write(8'h83, 32'hFFFF_FF2F);
      #1; chk("R6 slot3 wins", vec_addr_o, 32'hAAAA_0003);
      reg_read("R10 ctl upper bits zero", 8'h83);
      // R4: fast class line never vectored
      reg_write(8'h02, 32'h0000_8000);
      #1; chk("R4 vec default", vec_addr_o, 32'hDEAD_0000);
      chk("R2 fiq", {31'b0, fiq_o}, 32'h1);
      chk("R2 irq low", {31'b0, irq_o}, 32'h0);
      // R3: disable line
      reg_write(8'h05, 32'h0000_8000);
      #1; chk("R3 fiq off", {31'b0, fiq_o}, 32'h0);
      chk_out("R3");
      // R9: set/clear leave other bits
      reg_write(8'h03, 32'hF0F0_0000);
      reg_write(8'h04, 32'h0000_000F);
      reg_read("R9 set", 8'h03);
      reg_write(8'h05, 32'h3000_0001);
      reg_read("R9 clr", 8'h03);
      // R11: raw and masked status
      src_i = 32'h5555_AAAA;
      @(negedge clk);
      reg_read("R11 raw", 8'h00);
      reg_read("R11 masked", 8'h01);

      // constrained random mix
      for (int it = 0; it < 600; it++) begin
         int op;
         logic [31:0] d;
         op = int'($urandom_range(0, 7));
         d  = $urandom;
         case (op)
            0: reg_write(8'h02, d & $urandom);
            1: reg_write(8'h03, d);
            2: reg_write(8'h04, d);
            3: reg_write(8'h05, d);
            4: reg_write(8'h06, d);
            5: reg_write(8'h40 + 8'($urandom_range(0, NL-1)), d);
            6: reg_write(8'h80 + 8'($urandom_range(0, NL-1)), {26'b0, d[5:0]});
            default: @(negedge clk);
         endcase
         src_i = $urandom & $urandom;
         chk_out("rand");
         case ($urandom_range(0, 4))
            0: reg_read("R11 rand status", 8'($urandom_range(0, 1)));
            1: reg_read("R10 rand ctl", 8'h80 + 8'($urandom_range(0, NL-1)));
            2: reg_read("R10 rand adr", 8'h40 + 8'($urandom_range(0, NL-1)));
            3: reg_read("R11 rand handler", 8'h07);
            default: reg_read("R10 rand enable", 8'h03);
         endcase
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule